// File: doc/BRIEF.md
# Self-Timed SAR Conversion Controller

This block runs one 10-bit successive-approximation conversion for each rising edge of an external conversion clock. A fast system clock runs the logic. The external clock is treated as asynchronous: it passes through a synchronizer, and only its rising edge is acted on. When that edge is detected, the block ends the sampling phase in two steps. First it opens the switch that shorts the two DAC top plates. One system cycle later it opens the sample switch. It then runs the binary search, starting from the most significant bit.

The bit trials are not paced by a cycle count. The block sends a comparator start pulse and then waits for the comparator's done strobe, sampling that strobe on the system clock. When the strobe arrives, the block captures the decision and drives the capacitor pair of the resolved bit to the top or bottom reference. It then sends the next start pulse.

After the last decision the block does three things in the same cycle:
- it loads the 10-bit result;
- it pulses a result-valid flag;
- it returns to sampling, where it waits for the next external edge.

An external edge that arrives before the conversion is done is dropped, and a sticky overrun flag is set.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is held and right after it is released: `samp_o` and `short_o` are 1; `cmp_start_o`, `result_vld_o` and `overrun_o` are 0; `result_o`, `dac_hi_o` and `dac_lo_o` are all zero.
- R2: A rising edge on `conv_clk_i` passes through a two-stage synchronizer and acts on the third system clock edge after it. On that edge `short_o` falls while `samp_o` stays 1.
- R3: `short_o` always deasserts one system cycle before `samp_o` deasserts.
- R4: `cmp_start_o` is a one-cycle pulse. The first pulse comes in the cycle after `samp_o` falls. Each later pulse comes in the cycle after an accepted done strobe.
- R5: The search resolves bit 9 first and bit 0 last. `result_o[k]` equals the `cmp_bit_i` value captured with the done strobe for bit k.
- R6: Each bit k has a pair `dac_hi_o[k]`/`dac_lo_o[k]`. 00 means common mode, 10 means top reference (bit resolved to 1) and 01 means bottom reference (bit resolved to 0). Unresolved bits stay at 00. All pairs read 00 while sampling. 11 never occurs.
- R7: In the cycle after the tenth decision is captured, `result_vld_o` is 1 for one cycle, `result_o` holds the new code, and `samp_o` and `short_o` are 1 again. `result_o` changes only when `result_vld_o` is 1.
- R8: A `conv_clk_i` rising edge that arrives when the block is not waiting in the sampling phase does not change the conversion in progress, and it sets `overrun_o`. `overrun_o` then stays 1 until reset.
- R9: A `cmp_done_i` strobe that arrives when no comparator result is awaited is ignored. This covers the sampling phase and the cycle in which `cmp_start_o` is high.
- R10: Only rising edges of `conv_clk_i` matter. A falling edge, or a level held high through and past a conversion, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| conv_clk_i | input | 1 | External conversion clock (asynchronous) |
| cmp_bit_i | input | 1 | Comparator decision, valid with `cmp_done_i` |
| cmp_done_i | input | 1 | Comparator done strobe |
| samp_o | output | 1 | Sample switch control |
| short_o | output | 1 | Top-plate short control |
| cmp_start_o | output | 1 | Comparator start pulse |
| dac_hi_o | output | 10 | Per-bit switch to the top reference |
| dac_lo_o | output | 10 | Per-bit switch to the bottom reference |
| result_o | output | 10 | Last conversion code |
| result_vld_o | output | 1 | One-cycle pulse when `result_o` updates |
| overrun_o | output | 1 | Sticky flag for an external edge dropped during a conversion |

## Verification
The assertions rely on the following properties of the inputs:
- `cmp_done_i` is a one-cycle strobe that arrives no earlier than the cycle after the start pulse.
- `cmp_bit_i` is valid in the same cycle as `cmp_done_i`.
- `conv_clk_i` holds each level across at least one system clock edge.

The bench's comparator model follows these rules. It waits a random latency of one or more cycles after each start pulse, then raises done for exactly one cycle. It also keeps `conv_clk_i` low for three cycles before each new rising edge. Early and stray done strobes are sent only in the ignored windows, and only to check that they are ignored.

// File: rtl/sar_ctrl_pkg.sv
`timescale 1ns/1ps
package sar_ctrl_pkg;

  // Conversion sequencer phases
  typedef enum logic [2:0] {
    ST_TRACK   = 3'd0,  // sampling, top plates shorted
    ST_UNSHORT = 3'd1,  // short released, sample switch still closed
    ST_HOLD    = 3'd2,  // sample switch open, settle one cycle
    ST_FIRE    = 3'd3,  // comparator start pulse
    ST_WAIT    = 3'd4   // awaiting comparator done strobe
  } seq_state_e;

endpackage

// File: rtl/sar_edge_sync.sv
`timescale 1ns/1ps
module sar_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[TOP-1:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[TOP];
  end

  assign rise_o = sync_q[TOP] & ~prev_q;

endmodule

// File: rtl/sar_seq_fsm.sv
`timescale 1ns/1ps
module sar_seq_fsm
  import sar_ctrl_pkg::*;
#(
  parameter int NBITS = 10,
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             done_i,
  output logic             samp_o,
  output logic             short_o,
  output logic             start_o,
  output logic             clear_o,
  output logic             capture_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             overrun_o
);

  localparam logic [IDX_W-1:0] IDX_MSB = IDX_W'(NBITS - 1);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             ovr_q, ovr_d;

  // Handshake qualifiers
  assign capture_o = (state_q == ST_WAIT) && done_i;
  assign last_o    = capture_o && (idx_q == '0);
  assign clear_o   = (state_q == ST_TRACK) && go_i;

  // Next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    case (state_q)
      ST_TRACK: begin
        if (go_i) state_d = ST_UNSHORT;
      end
      ST_UNSHORT: state_d = ST_HOLD;
      ST_HOLD: begin
        state_d = ST_FIRE;
        idx_d   = IDX_MSB;
        idx_en  = 1'b1;
      end
      ST_FIRE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (done_i) begin
          if (idx_q == '0) begin
            state_d = ST_TRACK;
          end else begin
            state_d = ST_FIRE;
            idx_d   = idx_q - IDX_ONE;
            idx_en  = 1'b1;
          end
        end
      end
      default: state_d = ST_TRACK;
    endcase
  end

  // Overrun: an external edge outside the sampling phase
  always_comb begin
    ovr_d = ovr_q | (go_i && (state_q != ST_TRACK));
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TRACK;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // Moore decodes
  assign samp_o    = (state_q == ST_TRACK) || (state_q == ST_UNSHORT);
  assign short_o   = (state_q == ST_TRACK);
  assign start_o   = (state_q == ST_FIRE);
  assign idx_o     = idx_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/sar_trial_reg.sv
`timescale 1ns/1ps
module sar_trial_reg #(
  parameter int NBITS = 10,
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             capture_i,
  input  logic             last_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  output logic [NBITS-1:0] dac_hi_o,
  output logic [NBITS-1:0] dac_lo_o,
  output logic [NBITS-1:0] result_o,
  output logic             vld_o
);

  logic [NBITS-1:0] hi_q, lo_q;
  logic [NBITS-1:0] res_q, res_d;
  logic             vld_q;

  generate
    for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
      logic sel;
      logic pair_en;
      logic hi_d, lo_d;

      assign sel = (idx_i == IDX_W'(gi));

      always_comb begin
        pair_en = 1'b0;
        hi_d    = hi_q[gi];
        lo_d    = lo_q[gi];
        if (clear_i || last_i) begin
          pair_en = 1'b1;
          hi_d    = 1'b0;
          lo_d    = 1'b0;
        end else if (capture_i && sel) begin
          pair_en = 1'b1;
          hi_d    = bit_i;
          lo_d    = ~bit_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q[gi] <= 1'b0;
          lo_q[gi] <= 1'b0;
        end else if (pair_en) begin
          hi_q[gi] <= hi_d;
          lo_q[gi] <= lo_d;
        end
      end

      // Result assembly: the bit under trial comes straight from the comparator
      assign res_d[gi] = sel ? bit_i : hi_q[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (last_i) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= last_i;
  end

  assign dac_hi_o = hi_q;
  assign dac_lo_o = lo_q;
  assign result_o = res_q;
  assign vld_o    = vld_q;

endmodule

// File: rtl/sar_conv_seq.sv
`timescale 1ns/1ps
module sar_conv_seq #(
  parameter int NBITS       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_clk_i,
  input  logic             cmp_bit_i,
  input  logic             cmp_done_i,
  output logic             samp_o,
  output logic             short_o,
  output logic             cmp_start_o,
  output logic [NBITS-1:0] dac_hi_o,
  output logic [NBITS-1:0] dac_lo_o,
  output logic [NBITS-1:0] result_o,
  output logic             result_vld_o,
  output logic             overrun_o
);

  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic             go;
  logic             clear;
  logic             capture;
  logic             last;
  logic [IDX_W-1:0] idx;

  sar_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (conv_clk_i),
    .rise_o  (go)
  );

  sar_seq_fsm #(.NBITS(NBITS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .done_i    (cmp_done_i),
    .samp_o    (samp_o),
    .short_o   (short_o),
    .start_o   (cmp_start_o),
    .clear_o   (clear),
    .capture_o (capture),
    .last_o    (last),
    .idx_o     (idx),
    .overrun_o (overrun_o)
  );

  sar_trial_reg #(.NBITS(NBITS)) u_trial (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear),
    .capture_i (capture),
    .last_i    (last),
    .idx_i     (idx),
    .bit_i     (cmp_bit_i),
    .dac_hi_o  (dac_hi_o),
    .dac_lo_o  (dac_lo_o),
    .result_o  (result_o),
    .vld_o     (result_vld_o)
  );

endmodule

// File: rtl/sar_conv_seq_chk.sv
`timescale 1ns/1ps
module sar_conv_seq_chk #(
  parameter int NBITS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             samp_o,
  input logic             short_o,
  input logic             cmp_start_o,
  input logic [NBITS-1:0] dac_hi_o,
  input logic [NBITS-1:0] dac_lo_o,
  input logic [NBITS-1:0] result_o,
  input logic             result_vld_o,
  input logic             overrun_o
);

  // R2: the short opens while the sample switch is still closed
  p_short_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(short_o) |-> samp_o);

  // R3: the sample switch opens only after the short was already open
  p_short_leads_samp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_o) |-> !$past(short_o));

  // R4: the start is a single-cycle pulse
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start_o |=> !cmp_start_o);

  // R4: a start follows a cycle with the sample switch open
  p_start_after_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_start_o) |-> !$past(samp_o));

  // R6: a capacitor pair is never driven to both references
  p_dac_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_hi_o & dac_lo_o) == '0);

  // R6: all pairs sit at common mode while sampling
  p_dac_track_cm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    short_o |-> ((dac_hi_o | dac_lo_o) == '0));

  // R7: result-valid is a single-cycle pulse
  p_vld_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |=> !result_vld_o);

  // R7: the valid pulse coincides with the return to sampling
  p_vld_in_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |-> (samp_o && short_o));

  // R7: the result changes only together with the valid pulse
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld_o |-> $stable(result_o));

  // R8: overrun is sticky
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .samp_o       (samp_o),
  .short_o      (short_o),
  .cmp_start_o  (cmp_start_o),
  .dac_hi_o     (dac_hi_o),
  .dac_lo_o     (dac_lo_o),
  .result_o     (result_o),
  .result_vld_o (result_vld_o),
  .overrun_o    (overrun_o)
);

// File: tb/tb_sar_conv_seq.sv
`timescale 1ns/1ps
module tb_sar_conv_seq;

  localparam int NB = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          conv_clk;
  logic          cmp_bit;
  logic          cmp_done;
  logic          samp, short_c, start;
  logic [NB-1:0] dac_hi, dac_lo, result;
  logic          vld, overrun;

  int n_tests = 0;
  int n_fail  = 0;
  int hold_left = 0;

  always #5 clk = ~clk;

  sar_conv_seq #(.NBITS(NB)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_clk_i   (conv_clk),
    .cmp_bit_i    (cmp_bit),
    .cmp_done_i   (cmp_done),
    .samp_o       (samp),
    .short_o      (short_c),
    .cmp_start_o  (start),
    .dac_hi_o     (dac_hi),
    .dac_lo_o     (dac_lo),
    .result_o     (result),
    .result_vld_o (vld),
    .overrun_o    (overrun)
  );

  // Expected pair state once bits NB-1 down to lo_bit are resolved
  function automatic logic [NB-1:0] exp_hi(input logic [NB-1:0] t, input int lo_bit);
    logic [NB-1:0] m;
    m = (lo_bit >= NB) ? '0 : ({NB{1'b1}} << lo_bit);
    return t & m;
  endfunction

  function automatic logic [NB-1:0] exp_lo(input logic [NB-1:0] t, input int lo_bit);
    logic [NB-1:0] m;
    m = (lo_bit >= NB) ? '0 : ({NB{1'b1}} << lo_bit);
    return ~t & m;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Advance to the next falling edge; model the external clock high time
  task automatic tick();
    @(negedge clk);
    if (hold_left > 0) begin
      hold_left--;
      if (hold_left == 0) conv_clk = 1'b0;
    end
  endtask

  task automatic run_conv(input logic [NB-1:0] target, input int hi_time,
                          input int lat_max, input bit inj_early, input bit inj_ovr);
    if (conv_clk) begin
      conv_clk  = 1'b0;
      hold_left = 0;
    end
    repeat (3) tick();
    conv_clk  = 1'b1;
    hold_left = hi_time;
    tick(); tick();
    check(samp && short_c, "R2", "sampling held during sync", {samp, short_c}, 2'b11);
    tick();
    check(!short_c && samp, "R2", "short released first", {samp, short_c}, 2'b10);
    tick();
    check(!samp && !short_c && !start, "R3", "sample opens one cycle later",
          {samp, short_c, start}, 3'b000);
    tick();
    check(start, "R4", "first start after sample opens", start, 1);
    for (int i = NB - 1; i >= 0; i--) begin
      int lat;
      lat = $urandom_range(lat_max, 1);
      if (inj_early && i == NB - 3) begin
        cmp_done = 1'b1;
        cmp_bit  = ~target[i];
        tick();
        cmp_done = 1'b0;
        check(!start && dac_hi == exp_hi(target, i + 1) && dac_lo == exp_lo(target, i + 1),
              "R9", "done during start pulse ignored", {start, dac_hi},
              {1'b0, exp_hi(target, i + 1)});
      end
      if (inj_ovr && i == 4) begin
        conv_clk  = 1'b0;
        hold_left = 0;
        repeat (3) tick();
        conv_clk = 1'b1;
        repeat (4) tick();
        check(overrun, "R8", "overrun set by early edge", overrun, 1);
        check(!start && !samp && dac_hi == exp_hi(target, i + 1),
              "R8", "early edge leaves conversion alone", {start, samp, dac_hi},
              {2'b00, exp_hi(target, i + 1)});
      end
      repeat (lat) begin
        tick();
        check(!start, "R4", "start is one cycle wide", start, 0);
      end
      cmp_done = 1'b1;
      cmp_bit  = target[i];
      tick();
      cmp_done = 1'b0;
      cmp_bit  = 1'b0;
      if (i > 0) begin
        check(start, "R4", "next start after done", start, 1);
        check(dac_hi == exp_hi(target, i) && dac_lo == exp_lo(target, i),
              "R6", "pair switches after decision", {dac_hi, dac_lo},
              {exp_hi(target, i), exp_lo(target, i)});
      end else begin
        check(vld, "R7", "valid after tenth decision", vld, 1);
        check(result == target, "R5", "result code MSB first", result, target);
        check(samp && short_c, "R7", "back to sampling", {samp, short_c}, 2'b11);
        check(dac_hi == '0 && dac_lo == '0, "R6", "pairs at common mode in sampling",
              {dac_hi, dac_lo}, 0);
      end
    end
    tick();
    check(!vld && result == target, "R7", "valid is one pulse, result held",
          {vld, result}, {1'b0, target});
  endtask

  initial begin
    #2ms;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NB-1:0] last_res;
    void'($urandom(32'h5A17));
    rst_n    = 1'b0;
    conv_clk = 1'b0;
    cmp_bit  = 1'b0;
    cmp_done = 1'b0;
    repeat (3) @(negedge clk);
    check(samp && short_c && !start && !vld && !overrun && result == '0 &&
          dac_hi == '0 && dac_lo == '0, "R1", "state in reset",
          {samp, short_c, start, vld, overrun}, 5'b11000);
    rst_n = 1'b1;
    tick();
    check(samp && short_c && !start && !vld && !overrun && result == '0,
          "R1", "state after reset", {samp, short_c, start, vld, overrun}, 5'b11000);

    // Directed patterns
    run_conv(10'h3FF, 2, 1, 1'b0, 1'b0);
    run_conv(10'h000, 1, 3, 1'b0, 1'b0);
    run_conv(10'h2AA, 7, 2, 1'b0, 1'b0);
    run_conv(10'h155, 20, 4, 1'b1, 1'b0);

    // R9: a stray done strobe while sampling
    last_res = result;
    cmp_done = 1'b1;
    cmp_bit  = 1'b1;
    tick();
    cmp_done = 1'b0;
    cmp_bit  = 1'b0;
    tick();
    check(!vld && result == last_res && samp && short_c && dac_hi == '0 && !start,
          "R9", "done while sampling ignored", {vld, result}, {1'b0, last_res});

    // R10: level held high past the conversion, then a falling edge
    run_conv(10'h1C3, 0, 2, 1'b0, 1'b0);
    repeat (10) tick();
    check(samp && short_c && !start, "R10", "held level starts nothing",
          {samp, short_c, start}, 3'b110);
    conv_clk = 1'b0;
    repeat (6) tick();
    check(samp && short_c && !start && !overrun, "R10", "falling edge starts nothing",
          {samp, short_c, start, overrun}, 4'b1100);

    // Random conversions, varied duty and comparator latency
    for (int k = 0; k < 40; k++) begin
      run_conv(NB'($urandom), $urandom_range(60, 1), 6, 1'b0, 1'b0);
      check(!overrun, "R8", "no overrun on in-time edges", overrun, 0);
    end

    // R8: an edge during the conversion is dropped and flagged
    run_conv(10'h26B, 3, 3, 1'b0, 1'b1);
    run_conv(10'h0F0, 2, 2, 1'b0, 1'b0);
    check(overrun, "R8", "overrun stays set", overrun, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule